// File: doc/BRIEF.md
# Four-Mode Serial Port

This block is a full-duplex serial port for a small controller. Software sees two byte-wide locations. One is a control register that holds the mode field, the receive enable, the ninth transmit bit, the ninth received bit, two completion flags and a rate-doubling bit. The other is a data location. A write to the data location goes to the transmitter and starts a frame. A read from it returns the last byte the receiver accepted.

The two-bit mode field picks one of four framings:
- A synchronous 8-bit shifter, clocked at one twelfth of the block clock.
- A 10-bit asynchronous frame whose rate comes from an external timer overflow strobe.
- A 9-data-bit asynchronous frame at a fixed fraction of the block clock.
- A 9-data-bit asynchronous frame at the timer-derived rate.

The receiver oversamples each asynchronous bit sixteen times and decides it by a majority vote. It rejects false starts. It does not overwrite an unread byte.

Top module: `sio_port`

## Requirements
- R1: After reset the control register reads 0x00, the data location reads 0x00, `txd_o` is 1 and `rxd_oe` is 0.
- R2: With `bus_sel`=0 the bus reaches the control register. Its fields are: mode in bits 1:0, receive enable in bit 2, ninth transmit bit in bit 3, ninth received bit in bit 4, transmit-done in bit 5, receive-done in bit 6 and rate doubling in bit 7. With `bus_sel`=1 a write starts the transmitter, and `bus_rdata` shows the receive buffer.
- R3: In mode 01 the transmitter sends a 0 start bit, then 8 data bits least significant first, then a 1 stop bit. Each bit lasts 32 `tmr_ovf` strobes, or 16 strobes when bit 7 is set.
- R4: In mode 11 the frame carries a ninth data bit after the eight data bits, taken from control bit 3. Bit timing is the same as in R3.
- R5: In mode 10 the frame has the R4 layout, and each bit lasts 64 clock cycles, or 32 cycles when bit 7 is set.
- R6: Transmit-done (bit 5) is still 0 in the middle of the stop bit. It is set once the frame ends and stays set until software writes it to 0.
- R7: In the asynchronous modes the receiver finds a start bit by a falling edge and decides each bit by a majority of oversamples 7, 8 and 9 of 16. It assembles data least significant bit first. It then loads the buffer and sets receive-done (bit 6). Bit 4 takes the ninth bit in modes 10 and 11, and the stop bit in mode 01.
- R8: A start bit whose majority value is 1 is discarded, and nothing is received. The receiver then accepts the next valid frame.
- R9: While bit 2 is 0, asynchronous frames arriving on `rxd_i` are not received.
- R10: When a frame completes while receive-done is already 1, it is dropped, and the buffer keeps the earlier byte.
- R11: In mode 00 a data write shifts 8 bits out on `rxd_o` with `rxd_oe`=1, least significant first. `txd_o` carries the shift clock: 6 cycles low, then 6 cycles high per bit. Data is valid at each rising edge. Transmit-done is set at the end.
- R12: In mode 00, a control write with bit 2 set and bit 6 clear starts 8 shift clocks on `txd_o`. The port samples `rxd_i` at each rising shift-clock edge, least significant bit first, and then loads the buffer and sets receive-done.
- R13: A data write while the transmitter is busy is ignored. The frame in progress is unchanged, and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (oscillator) |
| rst | input | 1 | Synchronous active-high reset |
| tmr_ovf | input | 1 | One-cycle timer overflow strobe for the timer-driven rates |
| bus_we | input | 1 | Write strobe |
| bus_sel | input | 1 | 0 = control register, 1 = data location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected location |
| txd_o | output | 1 | Asynchronous transmit line, or shift clock in mode 00 |
| rxd_i | input | 1 | Receive line, or shift data in for mode 00 |
| rxd_o | output | 1 | Shift data out in mode 00 |
| rxd_oe | output | 1 | Drive enable for `rxd_o` |

## Verification
The hardest case to reach is a frame that completes while receive-done is still set. The stimulus has to deliver two complete frames back to back with no control write between them, because any control write would clear the flag. The bench does this by streaming a second oversampled frame straight after the first one is accepted. It then reads the buffer, clears the flag and sends a third frame to show that reception resumes. False starts are reached by driving a low pulse of a quarter bit, which ends before the vote samples.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [1:0] {
        MD_SHIFT = 2'b00,
        MD_UART8 = 2'b01,
        MD_FIX9  = 2'b10,
        MD_VAR9  = 2'b11
    } sio_mode_e;

    typedef struct packed {
        logic      dbl;
        logic      rx_done;
        logic      tx_done;
        logic      rx_b9;
        logic      tx_b9;
        logic      rx_en;
        sio_mode_e mode;
    } sio_ctrl_t;

    typedef struct packed {
        logic [7:0] data;
        logic       b9;
    } sio_frame_t;

    typedef enum logic [1:0] {
        T_IDLE,
        T_WAIT,
        T_ASYNC,
        T_SYNC
    } tx_state_e;

    localparam int SIO_SYNC_DIV = 12;
    localparam int SIO_FIX_DIV  = 64;
    localparam int SIO_TMR_DIV  = 32;
    localparam int SIO_OVS      = 16;

    function automatic logic is_timer_mode(sio_mode_e m);
        return (m == MD_UART8) || (m == MD_VAR9);
    endfunction

    function automatic logic is_nine(sio_mode_e m);
        return (m == MD_FIX9) || (m == MD_VAR9);
    endfunction

    function automatic logic majority3(logic a, logic b, logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/sio_baud.sv
module sio_baud
    import sio_pkg::*;
#(
    parameter int FIX_DIV = SIO_FIX_DIV,
    parameter int TMR_DIV = SIO_TMR_DIV,
    parameter int OVS     = SIO_OVS
) (
    input  logic      clk,
    input  logic      rst,
    input  sio_mode_e mode,
    input  logic      dbl,
    input  logic      tmr_ovf,
    output logic      samp_tick
);
    localparam int T_FULL = TMR_DIV / OVS;
    localparam int T_HALF = (T_FULL > 1) ? T_FULL / 2 : 1;
    localparam int F_FULL = FIX_DIV / OVS;
    localparam int F_HALF = (F_FULL > 1) ? F_FULL / 2 : 1;
    localparam int CW     = $clog2(F_FULL + T_FULL) + 1;
    localparam logic [CW-1:0] LT_FULL = CW'(T_FULL - 1);
    localparam logic [CW-1:0] LT_HALF = CW'(T_HALF - 1);
    localparam logic [CW-1:0] LF_FULL = CW'(F_FULL - 1);
    localparam logic [CW-1:0] LF_HALF = CW'(F_HALF - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_m1;
    logic          src;

    always_comb begin
        src    = is_timer_mode(mode) ? tmr_ovf : (mode != MD_SHIFT);
        lim_m1 = is_timer_mode(mode) ? (dbl ? LT_HALF : LT_FULL)
                                     : (dbl ? LF_HALF : LF_FULL);
        samp_tick = src && (cnt >= lim_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (src) begin
            cnt <= samp_tick ? '0 : cnt + 1'b1;
        end
    end

    AST_FIX_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        (samp_tick && mode == MD_FIX9) |=> (!samp_tick || mode != MD_FIX9)); // R5

    AST_TICK_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (samp_tick && is_timer_mode(mode)) |-> tmr_ovf); // R3

endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int SYNC_DIV = SIO_SYNC_DIV,
    parameter int OVS      = SIO_OVS
) (
    input  logic       clk,
    input  logic       rst,
    input  sio_mode_e  mode,
    input  logic       samp_tick,
    input  logic       start_tx,
    input  logic [7:0] tx_byte,
    input  logic       tx_b9,
    input  logic       start_srx,
    input  logic       rxd_i,
    output logic       txd,
    output logic       dat_o,
    output logic       dat_oe,
    output logic       tx_fin,
    output logic       srx_fin,
    output logic [7:0] srx_byte
);
    localparam int CW = $clog2(SYNC_DIV);
    localparam int PW = $clog2(OVS);
    localparam logic [CW-1:0] C_LAST = CW'(SYNC_DIV - 1);
    localparam logic [CW-1:0] C_MID  = CW'(SYNC_DIV / 2);
    localparam logic [PW-1:0] P_LAST = PW'(OVS - 1);

    tx_state_e     st;
    logic [10:0]   sh;
    logic [7:0]    rsh;
    logic [PW-1:0] ph;
    logic [CW-1:0] cnt;
    logic [3:0]    bitn;
    logic [3:0]    last_idx;
    logic          dir_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= T_IDLE;
            sh       <= '1;
            rsh      <= '0;
            ph       <= '0;
            cnt      <= '0;
            bitn     <= '0;
            last_idx <= '0;
            dir_rx   <= 1'b0;
            tx_fin   <= 1'b0;
            srx_fin  <= 1'b0;
        end else begin
            tx_fin  <= 1'b0;
            srx_fin <= 1'b0;
            unique case (st)
                T_IDLE: begin
                    if (start_srx) begin
                        st     <= T_SYNC;
                        dir_rx <= 1'b1;
                        cnt    <= '0;
                        bitn   <= '0;
                    end else if (start_tx) begin
                        dir_rx <= 1'b0;
                        cnt    <= '0;
                        ph     <= '0;
                        bitn   <= '0;
                        if (mode == MD_SHIFT) begin
                            st <= T_SYNC;
                            sh <= {3'b111, tx_byte};
                        end else begin
                            st       <= T_WAIT;
                            sh       <= {1'b1, (is_nine(mode) ? tx_b9 : 1'b1), tx_byte, 1'b0};
                            last_idx <= is_nine(mode) ? 4'd10 : 4'd9;
                        end
                    end
                end
                T_WAIT: begin
                    if (samp_tick) st <= T_ASYNC;
                end
                T_ASYNC: begin
                    if (samp_tick) begin
                        ph <= ph + 1'b1;
                        if (ph == P_LAST) begin
                            if (bitn == last_idx) begin
                                st     <= T_IDLE;
                                tx_fin <= 1'b1;
                            end else begin
                                sh   <= {1'b1, sh[10:1]};
                                bitn <= bitn + 1'b1;
                            end
                        end
                    end
                end
                T_SYNC: begin
                    if (cnt == C_MID && dir_rx) rsh <= {rxd_i, rsh[7:1]};
                    if (cnt == C_LAST) begin
                        cnt <= '0;
                        if (bitn == 4'd7) begin
                            st <= T_IDLE;
                            if (dir_rx) srx_fin <= 1'b1;
                            else        tx_fin  <= 1'b1;
                        end else begin
                            bitn <= bitn + 1'b1;
                            if (!dir_rx) sh <= {1'b1, sh[10:1]};
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    always_comb begin
        if (st == T_ASYNC)     txd = sh[0];
        else if (st == T_SYNC) txd = (cnt >= C_MID);
        else                   txd = 1'b1;
        dat_o    = sh[0];
        dat_oe   = (st == T_SYNC) && !dir_rx;
        srx_byte = rsh;
    end

    AST_SHIFT_DRIVE_MODE0: assert property (@(posedge clk) disable iff (rst)
        dat_oe |-> (mode == MD_SHIFT)); // R11

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        (st == T_WAIT && samp_tick) |=> !txd); // R3

endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int OVS = SIO_OVS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       nine,
    input  logic       samp_tick,
    input  logic       rxd_i,
    output logic       frame_ok,
    output sio_frame_t frm
);
    localparam int SW = $clog2(OVS);
    localparam logic [SW-1:0] S_A = SW'(OVS / 2 - 1);
    localparam logic [SW-1:0] S_B = SW'(OVS / 2);
    localparam logic [SW-1:0] S_C = SW'(OVS / 2 + 1);

    logic [1:0]    sync;
    logic          rxs;
    logic          run;
    logic          last;
    logic [SW-1:0] scnt;
    logic [SW-1:0] scnt_n;
    logic [3:0]    bidx;
    logic [3:0]    last_idx;
    logic          v0, v1;
    logic          bit_v;

    always_comb begin
        rxs      = sync[1];
        scnt_n   = scnt + 1'b1;
        bit_v    = majority3(v0, v1, rxs);
        last_idx = nine ? 4'd10 : 4'd9;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync     <= 2'b11;
            run      <= 1'b0;
            last     <= 1'b1;
            scnt     <= '0;
            bidx     <= '0;
            v0       <= 1'b1;
            v1       <= 1'b1;
            frm      <= '0;
            frame_ok <= 1'b0;
        end else begin
            sync     <= {sync[0], rxd_i};
            frame_ok <= 1'b0;
            if (!enable) begin
                run  <= 1'b0;
                last <= 1'b1;
            end else if (samp_tick) begin
                if (!run) begin
                    last <= rxs;
                    if (last && !rxs) begin
                        run  <= 1'b1;
                        scnt <= '0;
                        bidx <= '0;
                    end
                end else begin
                    scnt <= scnt_n;
                    if (scnt_n == '0) bidx <= bidx + 1'b1;
                    if (scnt_n == S_A) v0 <= rxs;
                    if (scnt_n == S_B) v1 <= rxs;
                    if (scnt_n == S_C) begin
                        if (bidx == 4'd0) begin
                            if (bit_v) begin
                                run  <= 1'b0;
                                last <= rxs;
                            end
                        end else if (bidx <= 4'd8) begin
                            frm.data <= {bit_v, frm.data[7:1]};
                        end
                        if (bidx == 4'd9) frm.b9 <= bit_v;
                        if (bidx == last_idx) begin
                            run      <= 1'b0;
                            frame_ok <= 1'b1;
                            last     <= rxs;
                        end
                    end
                end
            end
        end
    end

    AST_NO_RX_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !frame_ok); // R9

endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int SYNC_DIV = SIO_SYNC_DIV,
    parameter int FIX_DIV  = SIO_FIX_DIV,
    parameter int TMR_DIV  = SIO_TMR_DIV,
    parameter int OVS      = SIO_OVS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tmr_ovf,
    input  logic       bus_we,
    input  logic       bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       txd_o,
    input  logic       rxd_i,
    output logic       rxd_o,
    output logic       rxd_oe
);
    sio_ctrl_t  ctrl;
    sio_ctrl_t  wcfg;
    logic [7:0] rbuf;
    logic       wr_ctrl, wr_buf, start_srx;
    logic       samp_tick;
    logic       tx_fin, srx_fin, frame_ok, got;
    logic [7:0] srx_byte, got_byte;
    sio_frame_t frm;

    always_comb begin
        wcfg      = sio_ctrl_t'(bus_wdata);
        wr_ctrl   = bus_we && !bus_sel;
        wr_buf    = bus_we && bus_sel;
        start_srx = wr_ctrl && (wcfg.mode == MD_SHIFT) && wcfg.rx_en && !wcfg.rx_done;
        got       = frame_ok || srx_fin;
        got_byte  = srx_fin ? srx_byte : frm.data;
        bus_rdata = bus_sel ? rbuf : ctrl;
    end

    sio_baud #(.FIX_DIV(FIX_DIV), .TMR_DIV(TMR_DIV), .OVS(OVS)) u_baud (
        .clk(clk), .rst(rst), .mode(ctrl.mode), .dbl(ctrl.dbl),
        .tmr_ovf(tmr_ovf), .samp_tick(samp_tick)
    );

    sio_tx #(.SYNC_DIV(SYNC_DIV), .OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .mode(ctrl.mode), .samp_tick(samp_tick),
        .start_tx(wr_buf), .tx_byte(bus_wdata), .tx_b9(ctrl.tx_b9),
        .start_srx(start_srx), .rxd_i(rxd_i), .txd(txd_o), .dat_o(rxd_o),
        .dat_oe(rxd_oe), .tx_fin(tx_fin), .srx_fin(srx_fin), .srx_byte(srx_byte)
    );

    sio_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst(rst),
        .enable(ctrl.rx_en && ctrl.mode != MD_SHIFT),
        .nine(is_nine(ctrl.mode)), .samp_tick(samp_tick), .rxd_i(rxd_i),
        .frame_ok(frame_ok), .frm(frm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            rbuf <= '0;
        end else begin
            if (wr_ctrl) ctrl <= wcfg;
            if (tx_fin) ctrl.tx_done <= 1'b1;
            if (got && !ctrl.rx_done) begin
                rbuf         <= got_byte;
                ctrl.rx_done <= 1'b1;
                if (frame_ok) ctrl.rx_b9 <= frm.b9;
            end
        end
    end

    AST_TXDONE_SET: assert property (@(posedge clk) disable iff (rst)
        tx_fin |=> ctrl.tx_done); // R6

    AST_TXDONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctrl.tx_done && !wr_ctrl) |=> ctrl.tx_done); // R6

    AST_RXDONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctrl.rx_done && !wr_ctrl) |=> ctrl.rx_done); // R7

    AST_RBUF_HELD: assert property (@(posedge clk) disable iff (rst)
        ctrl.rx_done |=> (rbuf == $past(rbuf))); // R10

endmodule

// File: tb/tb_sio_port.sv
module tb_sio_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tmr_ovf = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       txd_o, rxd_o, rxd_oe;
    logic       rxd_i = 1'b1;
    int         n_run = 0;
    int         n_fail = 0;
    int         cyc = 0;
    bit         done = 1'b0;

    sio_port dut (
        .clk(clk), .rst(rst), .tmr_ovf(tmr_ovf), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd_o(txd_o), .rxd_i(rxd_i),
        .rxd_o(rxd_o), .rxd_oe(rxd_oe)
    );

    always #10 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // timer overflow strobe every 2 clocks
    initial forever begin
        @(negedge clk);
        tmr_ovf = ~tmr_ovf;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_cfg(input logic [1:0] md, input logic ren,
                                          input logic tb8, input logic dbl);
        return {dbl, 1'b0, 1'b0, 1'b0, tb8, ren, md};
    endfunction

    task automatic bus_wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] ctrl_now();
        return bus_rdata;
    endfunction

    task automatic peek_buf(output logic [7:0] v);
        bus_sel = 1'b1;
        #1;
        v = bus_rdata;
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic wait_rise();
        logic pv;
        do begin
            pv = txd_o;
            @(negedge clk);
        end while (!(txd_o && !pv));
    endtask

    task automatic wait_fall();
        logic pv;
        do begin
            pv = txd_o;
            @(negedge clk);
        end while (!(!txd_o && pv));
    endtask

    // decode one asynchronous frame and check its content and tx_done timing
    task automatic tx_frame(input string tag, input logic nine, input int p,
                            input logic [7:0] d, input logic b9);
        logic [7:0] got;
        logic       st, sp, g9;
        bus_wr(1'b1, d);
        while (txd_o) @(negedge clk);
        wait_clk(p / 2);
        st = txd_o;
        for (int i = 0; i < 8; i++) begin
            wait_clk(p);
            got[i] = txd_o;
        end
        g9 = 1'b1;
        if (nine) begin
            wait_clk(p);
            g9 = txd_o;
        end
        wait_clk(p);
        sp = txd_o;
        chk(st == 1'b0, {tag, " start bit"}, st, 0);
        chk(got == d, {tag, " data"}, got, d);
        if (nine) chk(g9 == b9, {tag, " ninth bit"}, g9, b9);
        chk(sp == 1'b1, {tag, " stop bit"}, sp, 1);
        chk(ctrl_now()[5] == 1'b0, "R6 tx_done clear mid stop", ctrl_now()[5], 0);
        wait_clk(p);
        chk(ctrl_now()[5] == 1'b1, "R6 tx_done after frame", ctrl_now()[5], 1);
    endtask

    task automatic rx_send(input logic nine, input int p, input logic [7:0] d, input logic b9);
        rxd_i = 1'b0;
        wait_clk(p);
        for (int i = 0; i < 8; i++) begin
            rxd_i = d[i];
            wait_clk(p);
        end
        if (nine) begin
            rxd_i = b9;
            wait_clk(p);
        end
        rxd_i = 1'b1;
        wait_clk(p + 4);
    endtask

    logic [7:0] v, a, b, c, seed;
    logic       r9;
    int         t0;
    int         per;

    initial begin
        seed = 8'($urandom(32'd4242));
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // R1 reset state
        chk(ctrl_now() == 8'h00, "R1 control after reset", ctrl_now(), 0);
        peek_buf(v);
        chk(v == 8'h00, "R1 buffer after reset", v, 0);
        chk(txd_o == 1'b1, "R1 txd idle", txd_o, 1);
        chk(rxd_oe == 1'b0, "R1 rxd_oe", rxd_oe, 0);
        // R2 control register readback
        bus_wr(1'b0, mk_cfg(2'b11, 1'b0, 1'b1, 1'b1));
        chk(ctrl_now() == 8'h8B, "R2 control readback", ctrl_now(), 8'h8B);

        // R3 mode 01, random bytes and doubling
        for (int k = 0; k < 3; k++) begin
            r9 = 1'($urandom);
            bus_wr(1'b0, mk_cfg(2'b01, 1'b0, 1'b0, r9));
            tx_frame("R3 mode01", 1'b0, r9 ? 32 : 64, 8'($urandom), 1'b1);
        end
        // R6 clear by software
        bus_wr(1'b0, mk_cfg(2'b01, 1'b0, 1'b0, 1'b0));
        chk(ctrl_now()[5] == 1'b0, "R6 tx_done cleared", ctrl_now()[5], 0);
        // R4 mode 11 with ninth bit
        for (int k = 0; k < 2; k++) begin
            r9 = 1'(k);
            bus_wr(1'b0, mk_cfg(2'b11, 1'b0, r9, 1'b0));
            tx_frame("R4 mode11", 1'b1, 64, 8'($urandom), r9);
        end
        // R5 mode 10, both rates
        bus_wr(1'b0, mk_cfg(2'b10, 1'b0, 1'b1, 1'b0));
        tx_frame("R5 mode10 slow", 1'b1, 64, 8'hA5, 1'b1);
        bus_wr(1'b0, mk_cfg(2'b10, 1'b0, 1'b0, 1'b1));
        tx_frame("R5 mode10 fast", 1'b1, 32, 8'h3C, 1'b0);

        // R13 write while busy ignored
        bus_wr(1'b0, mk_cfg(2'b01, 1'b0, 1'b0, 1'b1));
        fork
            tx_frame("R13 first frame kept", 1'b0, 32, 8'h96, 1'b1);
            begin wait_clk(3); bus_wr(1'b1, 8'h0F); end
        join
        t0 = 0;
        for (int i = 0; i < 96; i++) begin
            @(negedge clk);
            if (!txd_o) t0++;
        end
        chk(t0 == 0, "R13 no second frame", t0, 0);

        // R7 receive mode 01
        a = 8'($urandom);
        bus_wr(1'b0, mk_cfg(2'b01, 1'b1, 1'b0, 1'b0));
        rx_send(1'b0, 64, a, 1'b1);
        chk(ctrl_now()[6] == 1'b1, "R7 rx_done mode01", ctrl_now()[6], 1);
        chk(ctrl_now()[4] == 1'b1, "R7 stop in bit4", ctrl_now()[4], 1);
        peek_buf(v);
        chk(v == a, "R7 rx byte mode01", v, a);
        // R7 receive mode 11 fast with ninth bit 0
        a = 8'($urandom);
        bus_wr(1'b0, mk_cfg(2'b11, 1'b1, 1'b0, 1'b1));
        rx_send(1'b1, 32, a, 1'b0);
        chk(ctrl_now()[6] == 1'b1, "R7 rx_done mode11", ctrl_now()[6], 1);
        chk(ctrl_now()[4] == 1'b0, "R7 ninth in bit4", ctrl_now()[4], 0);
        peek_buf(v);
        chk(v == a, "R7 rx byte mode11", v, a);

        // R8 false start
        bus_wr(1'b0, mk_cfg(2'b01, 1'b1, 1'b0, 1'b0));
        peek_buf(b);
        rxd_i = 1'b0;
        wait_clk(16);
        rxd_i = 1'b1;
        wait_clk(700);
        chk(ctrl_now()[6] == 1'b0, "R8 false start ignored", ctrl_now()[6], 0);
        peek_buf(v);
        chk(v == b, "R8 buffer unchanged", v, b);
        a = 8'h5A;
        rx_send(1'b0, 64, a, 1'b1);
        peek_buf(v);
        chk(v == a && ctrl_now()[6], "R8 next frame accepted", v, a);

        // R10 overrun drop
        bus_wr(1'b0, mk_cfg(2'b10, 1'b1, 1'b0, 1'b0));
        a = 8'($urandom); b = ~a; c = 8'($urandom);
        rx_send(1'b1, 64, a, 1'b1);
        rx_send(1'b1, 64, b, 1'b0);
        peek_buf(v);
        chk(v == a, "R10 second byte dropped", v, a);
        chk(ctrl_now()[4] == 1'b1, "R10 ninth bit kept", ctrl_now()[4], 1);
        bus_wr(1'b0, mk_cfg(2'b10, 1'b1, 1'b0, 1'b0));
        rx_send(1'b1, 64, c, 1'b0);
        peek_buf(v);
        chk(v == c, "R10 reception resumes", v, c);

        // R9 receive disabled
        bus_wr(1'b0, mk_cfg(2'b01, 1'b0, 1'b0, 1'b0));
        rx_send(1'b0, 64, 8'hC3, 1'b1);
        chk(ctrl_now()[6] == 1'b0, "R9 no rx when disabled", ctrl_now()[6], 0);
        peek_buf(v);
        chk(v == c, "R9 buffer unchanged", v, c);

        // R11 mode 00 transmit
        bus_wr(1'b0, mk_cfg(2'b00, 1'b0, 1'b0, 1'b0));
        a = 8'($urandom) ^ seed;
        bus_wr(1'b1, a);
        per = 0;
        t0 = 0;
        for (int i = 0; i < 8; i++) begin
            wait_rise();
            if (i > 0) per = (cyc - t0 != 12) ? per + 1 : per;
            t0 = cyc;
            chk(rxd_oe && (rxd_o == a[i]), "R11 shift data bit", {rxd_oe, rxd_o}, {1'b1, a[i]});
        end
        chk(per == 0, "R11 shift clock period", per, 0);
        wait_clk(20);
        chk(ctrl_now()[5] == 1'b1, "R11 tx_done mode00", ctrl_now()[5], 1);
        chk(rxd_oe == 1'b0, "R11 oe released", rxd_oe, 0);

        // R12 mode 00 receive
        b = 8'($urandom);
        rxd_i = b[0];
        bus_wr(1'b0, mk_cfg(2'b00, 1'b1, 1'b0, 1'b0));
        for (int i = 1; i < 8; i++) begin
            wait_rise();
            wait_fall();
            rxd_i = b[i];
        end
        wait_clk(20);
        rxd_i = 1'b1;
        chk(ctrl_now()[6] == 1'b1, "R12 rx_done mode00", ctrl_now()[6], 1);
        peek_buf(v);
        chk(v == b, "R12 shifted-in byte", v, b);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule